// File: doc/BRIEF.md
# Serial Receive Queue with Trigger-Level Interrupt

This block takes one asynchronous serial line and turns it into 8-bit characters. It oversamples the line using a strobe that pulses sixteen times per bit period. A character starts only when the line falls while the receiver is idle. The start bit is checked at its middle. If the line is high again at that point, the attempt is dropped and nothing is stored. The eight data bits follow, least significant first, and then a stop bit. Each of them is sampled sixteen ticks after the sample before it.

Finished characters enter a receive queue. The CPU side drains the queue through a valid/ready stream. `rxq_valid` is high whenever the queue holds a character, and `rxq_data` shows the oldest one. A character is removed on a clock edge where both `rxq_valid` and `rxq_ready` are high. While `rxq_ready` is low, the consumer applies back-pressure: the head character and `rxq_valid` stay unchanged. The write side of the queue has no back-pressure. The serial line cannot be paused, so a character that completes while the queue is full is discarded and the overrun flag is raised.

An interrupt request rises when the fill count reaches a selectable threshold and interrupts are enabled. A low stop bit raises a framing flag. Both error flags hold until a clear pulse.

Top module: `serial_rx_queue`

## Requirements
- R1: A character is captured least-significant bit first. The start bit is sampled 8 ticks after the falling edge is detected, and each data bit and the stop bit 16 ticks after the previous sample. Characters leave the queue in arrival order.
- R2: If the line reads high at the mid-start-bit sample, reception is abandoned and the fill count does not change.
- R3: A new reception needs a high-to-low transition while idle. A line that stays low after a character ends starts no further character.
- R4: A stop bit sampled low sets `frame_err` (1 = framing error seen). The character is still stored if there is room.
- R5: The queue holds at most DEPTH characters (64 by default). When it is full, nothing is written, and the stored characters and their order are kept.
- R6: A character that completes while the queue is full sets `overrun`. Both `overrun` and `frame_err` stay set until a one-cycle `err_clr` pulse clears them.
- R7: `thresh_sel` selects the interrupt level: 0 gives 1 character, 1 gives DEPTH/4, 2 gives DEPTH/2, and 3 gives DEPTH minus DEPTH/8 (1, 16, 32 and 56 at depth 64). `irq` is high while `irq_en` is 1 and `fill_count` is at or above the level, so reads that bring the count below the level drop it.
- R8: With `irq_en` at 0, `irq` stays low whatever the fill count.
- R9: `rxq_valid` equals "fill count above zero" and `rxq_data` is the oldest character. While `rxq_valid` is high and `rxq_ready` is low, both hold steady.
- R10: After reset the queue is empty and `irq`, `overrun` and `frame_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| thresh_sel | input | 2 | Interrupt threshold code |
| irq_en | input | 1 | Receive interrupt enable |
| err_clr | input | 1 | Clears the overrun and framing flags |
| rxq_valid | output | 1 | Queue holds a character |
| rxq_ready | input | 1 | Consumer accepts the head character |
| rxq_data | output | 8 | Oldest queued character |
| fill_count | output | $clog2(DEPTH)+1 | Number of stored characters |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky overrun flag |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
A table of characters is sent one at a time: alternating bits, all ones, all zeros, single set bits at each end, and both good and low stop bits. Each is read back, which separates bit-order and sample-position faults from framing-flag faults. A start pulse shorter than half a bit and a line held low after a bad stop bit show whether the receiver rejects false starts and waits for a real edge. One long run fills the queue past capacity. Along the way the interrupt is checked just below and exactly at each of the four thresholds, then with interrupts disabled, then at overflow for the overrun flag and kept contents, and finally while draining under back-pressure.

// File: rtl/srq_pkg.sv
package srq_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srq_bit_sampler.sv
module srq_bit_sampler
  import srq_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          tick_i,
  output logic          char_vld_o,
  output logic [DW-1:0] char_o,
  output logic          stop_bad_o
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [TW-1:0] T_HALF = TW'(OVS/2 - 1);
  localparam logic [TW-1:0] T_FULL = TW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  rx_state_e       st_q;
  logic [TW-1:0]   tcnt_q;
  logic [BW-1:0]   bcnt_q;
  logic [DW-1:0]   shreg_q;
  logic            sync1_q, sync2_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RX_IDLE;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      shreg_q    <= '0;
      last_q     <= 1'b0;
      char_vld_o <= 1'b0;
      char_o     <= '0;
      stop_bad_o <= 1'b0;
    end else begin
      char_vld_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            last_q <= sync2_q;
            if (last_q && !sync2_q) begin
              st_q   <= RX_START;
              tcnt_q <= '0;
            end
          end
          RX_START: begin
            if (tcnt_q == T_HALF) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              if (sync2_q) begin
                st_q   <= RX_IDLE;
                last_q <= 1'b1;
              end else begin
                st_q <= RX_DATA;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt_q == T_FULL) begin
              tcnt_q  <= '0;
              shreg_q <= {sync2_q, shreg_q[DW-1:1]};
              if (bcnt_q == B_LAST) st_q <= RX_STOP;
              else                  bcnt_q <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt_q == T_FULL) begin
              tcnt_q     <= '0;
              char_vld_o <= 1'b1;
              char_o     <= shreg_q;
              stop_bad_o <= !sync2_q;
              last_q     <= sync2_q;
              st_q       <= RX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R1
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld_o |=> !char_vld_o);

  // R2
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START) && tick_i && (tcnt_q == T_HALF) && sync2_q |=> (st_q == RX_IDLE) && !char_vld_o);
endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [DW-1:0]              din_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              dout_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_wr, do_rd;

  assign full_o  = (cnt_q == FULL_CNT);
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wr_q <= wr_q + 1'b1;
      if (do_rd) rd_q <= rd_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R5
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && push_i && !pop_i |=> full_o && $stable(rd_q));
endmodule

// File: rtl/srq_irq_gen.sv
module srq_irq_gen #(
  parameter int DEPTH = 64
) (
  input  logic [1:0]             sel_i,
  input  logic                   en_i,
  input  logic [$clog2(DEPTH):0] count_i,
  output logic                   irq_o
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] LVL0 = CW'(1);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH - DEPTH / 8);

  logic [CW-1:0] level;

  always_comb begin
    unique case (sel_i)
      2'd0:    level = LVL0;
      2'd1:    level = LVL1;
      2'd2:    level = LVL2;
      default: level = LVL3;
    endcase
  end

  assign irq_o = en_i && (count_i >= level);

  // R8
  always_comb begin
    disabled_quiet_chk: assert (en_i || !irq_o);
  end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH = 64,
  parameter int OVS   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_line,
  input  logic                       tick16,
  input  logic [1:0]                 thresh_sel,
  input  logic                       irq_en,
  input  logic                       err_clr,
  output logic                       rxq_valid,
  input  logic                       rxq_ready,
  output logic [7:0]                 rxq_data,
  output logic [$clog2(DEPTH):0]     fill_count,
  output logic                       irq,
  output logic                       overrun,
  output logic                       frame_err
);
  localparam int DW = 8;

  logic          ch_vld, ch_stop_bad, q_full;
  logic [DW-1:0] ch_data;
  logic          ovr_q, ferr_q;

  srq_bit_sampler #(.OVS(OVS), .DW(DW)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (rx_line),
    .tick_i     (tick16),
    .char_vld_o (ch_vld),
    .char_o     (ch_data),
    .stop_bad_o (ch_stop_bad)
  );

  srq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (ch_vld),
    .din_i   (ch_data),
    .pop_i   (rxq_valid && rxq_ready),
    .dout_o  (rxq_data),
    .count_o (fill_count),
    .full_o  (q_full)
  );

  srq_irq_gen #(.DEPTH(DEPTH)) u_irq (
    .sel_i   (thresh_sel),
    .en_i    (irq_en),
    .count_i (fill_count),
    .irq_o   (irq)
  );

  assign rxq_valid = (fill_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (ch_vld && q_full)          ovr_q <= 1'b1;
      else if (err_clr)              ovr_q <= 1'b0;
      if (ch_vld && ch_stop_bad)     ferr_q <= 1'b1;
      else if (err_clr)              ferr_q <= 1'b0;
    end
  end

  assign overrun   = ovr_q;
  assign frame_err = ferr_q;

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_vld && q_full |=> overrun);

  // R4
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_vld && ch_stop_bad |=> frame_err);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_valid && !rxq_ready |=> rxq_valid && $stable(rxq_data));
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int TDIV  = 4;
  localparam int NVEC  = 6;
  // {data, stop bit, expected framing flag}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h55, 1'b1, 1'b0},
    {8'hA3, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0},
    {8'h80, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic tick16 = 1'b0;
  logic [1:0] thresh_sel = 2'd0;
  logic irq_en = 1'b0;
  logic err_clr = 1'b0;
  logic rxq_ready = 1'b0;
  logic rxq_valid, irq, overrun, frame_err;
  logic [7:0] rxq_data;
  logic [CW-1:0] fill_count;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int div = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div    <= (div == TDIV-1) ? 0 : div + 1;
    tick16 <= (div == TDIV-1);
    cyc    <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  serial_rx_queue #(.DEPTH(DEPTH), .OVS(16)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .thresh_sel(thresh_sel), .irq_en(irq_en), .err_clr(err_clr),
    .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .rxq_data(rxq_data),
    .fill_count(fill_count), .irq(irq), .overrun(overrun), .frame_err(frame_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  task automatic hold_ticks(input int n);
    for (int k = 0; k < n; k++) wait_tick();
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop);
    rx_line = 1'b1; hold_ticks(4);
    rx_line = 1'b0; hold_ticks(16);
    for (int k = 0; k < 8; k++) begin
      rx_line = b[k]; hold_ticks(16);
    end
    rx_line = stop; hold_ticks(16);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk); rxq_ready = 1'b1;
    @(negedge clk); rxq_ready = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  function automatic logic [7:0] fill_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 fill", int'(fill_count), 0);
    check("R10 valid", int'(rxq_valid), 0);
    check("R10 irq", int'(irq), 0);
    check("R10 overrun", int'(overrun), 0);
    check("R10 frame_err", int'(frame_err), 0);

    // R1 / R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      send_char(VEC[v][9:2], VEC[v][1]);
      check("R1 fill", int'(fill_count), 1);
      check("R1 data", int'(rxq_data), int'(VEC[v][9:2]));
      check("R4 frame_err", int'(frame_err), int'(VEC[v][0]));
      pop_one();
      clear_flags();
      check("R6 flag clear", int'(frame_err), 0);
    end

    // R2 false start: low for 4 ticks only
    rx_line = 1'b1; hold_ticks(4);
    rx_line = 1'b0; hold_ticks(4);
    rx_line = 1'b1; hold_ticks(40);
    check("R2 fill", int'(fill_count), 0);
    check("R2 valid", int'(rxq_valid), 0);

    // R3 line stays low after bad stop bit
    send_char(8'h3C, 1'b0);
    hold_ticks(48);
    rx_line = 1'b1; hold_ticks(20);
    check("R3 fill", int'(fill_count), 1);
    check("R3 data", int'(rxq_data), 8'h3C);
    check("R4 stored with bad stop", int'(frame_err), 1);
    pop_one();
    clear_flags();

    // R7 / R8 fill the queue
    irq_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      send_char(fill_val(i), 1'b1);
      if (i + 1 == 1)  begin thresh_sel = 2'd0; @(negedge clk); check("R7 sel0 at 1", int'(irq), 1); end
      if (i + 1 == 15) begin thresh_sel = 2'd1; @(negedge clk); check("R7 sel1 at 15", int'(irq), 0); end
      if (i + 1 == 16) begin check("R7 sel1 at 16", int'(irq), 1); end
      if (i + 1 == 31) begin thresh_sel = 2'd2; @(negedge clk); check("R7 sel2 at 31", int'(irq), 0); end
      if (i + 1 == 32) begin check("R7 sel2 at 32", int'(irq), 1); end
      if (i + 1 == 55) begin thresh_sel = 2'd3; @(negedge clk); check("R7 sel3 at 55", int'(irq), 0); end
      if (i + 1 == 56) begin
        check("R7 sel3 at 56", int'(irq), 1);
        irq_en = 1'b0; @(negedge clk);
        check("R8 disabled", int'(irq), 0);
        irq_en = 1'b1;
      end
    end
    check("R5 full count", int'(fill_count), DEPTH);
    check("R6 no overrun yet", int'(overrun), 0);

    // R5 / R6 overflow
    send_char(8'hEE, 1'b1);
    check("R6 overrun set", int'(overrun), 1);
    check("R5 count held", int'(fill_count), DEPTH);
    check("R5 head kept", int'(rxq_data), int'(fill_val(0)));

    // R9 back-pressure
    repeat (5) @(negedge clk);
    check("R9 valid held", int'(rxq_valid), 1);
    check("R9 data held", int'(rxq_data), int'(fill_val(0)));

    clear_flags();
    check("R6 overrun clear", int'(overrun), 0);

    // R1 / R5 drain in order; R7 drop below level
    for (int i = 0; i < DEPTH; i++) begin
      check("R5 order", int'(rxq_data), int'(fill_val(i)));
      pop_one();
      if (i == 8) check("R7 below level", int'(irq), 0);
    end
    check("R9 empty", int'(rxq_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule